// File: doc/BRIEF.md
# Quadrature Decoder with Selectable Scaling

This block turns the two phase signals of an incremental encoder into count requests for a separate up/down counter. Each phase first passes through a synchronizer. The block then compares the new sample with the previous one. On each clock cycle it produces either nothing or a single-cycle count pulse, together with a direction bit that tells the counter whether to add or subtract.

A two-bit scaling field selects what counts as a count event. In the plain clock/direction mode, phase A is a count clock and phase B is a direction level. In X1, X2 and X4, more edges of the Gray-coded phase pair count, so one encoder cycle gives one, two or four counts. A separate input-enable bit can suppress all counting while the synchronizers keep following the inputs.

Top module: `quad_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first counted edge, `cnt_pulse` and `cnt_up` are both 0.
- R2: `scale` selects the mode: 2'b00 is clock/direction, 2'b01 is X1, 2'b10 is X2 and 2'b11 is X4.
- R3: While `ab_en` is 0, no edge on either phase produces a `cnt_pulse`. While it is 1, edges are counted according to `scale`.
- R4: In clock/direction mode, only a rising edge of A counts. `cnt_up` is 1 when B is low and 0 when B is high. B changing alone never counts, and a rising edge of A still counts when B changes in the same sample.
- R5: In X1 mode, only a rising edge of A counts. `cnt_up` is 1 when B is low and 0 when B is high.
- R6: In X2 mode, both edges of A count and edges of B never count. The direction follows the Gray-code order, with up meaning that A leads B.
- R7: In X4 mode, every edge of A or B counts. The sequence {A,B} = 00,10,11,01,00 is up, and the reverse order is down.
- R8: In the three quadrature modes, a sample in which both phases change at once produces no count.
- R9: A counted input change gives a `cnt_pulse` one cycle wide, in the cycle that follows the third rising clock edge after the change is applied. A full encoder cycle gives 1, 2 and 4 pulses in X1, X2 and X4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ab_en | input | 1 | Input enable; 0 suppresses all counts |
| scale | input | 2 | Mode: 00 clock/dir, 01 X1, 10 X2, 11 X4 |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| cnt_pulse | output | 1 | One-cycle count request |
| cnt_up | output | 1 | Direction of the latest count, 1 = up |

## Verification
An input change reaches the edge detector after two synchronizer edges, and the registered pulse appears after the third rising edge. The bench drives the phases just after a falling edge. It then samples at the falling edges after the second, third and fourth rising edges: it expects no pulse, then the expected pulse and direction, then no pulse again. Every step lets the block settle completely, so each edge is judged on its own, and a full cycle gives the expected count through the pulses it yields.

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ab_en,
  input  logic [1:0] scale,
  input  logic       enc_a,
  input  logic       enc_b,
  output logic       cnt_pulse,
  output logic       cnt_up
);

  localparam int MSB = SYNC_STAGES - 1;
  localparam logic [1:0] M_CLKDIR = 2'b00;
  localparam logic [1:0] M_X1     = 2'b01;
  localparam logic [1:0] M_X2     = 2'b10;
  localparam logic [1:0] M_X4     = 2'b11;

  logic [MSB:0] a_sync, b_sync;
  logic a_prev, b_prev;
  logic hit, dir;

  wire a_now    = a_sync[MSB];
  wire b_now    = b_sync[MSB];
  wire a_chg    = a_now ^ a_prev;
  wire b_chg    = b_now ^ b_prev;
  wire a_rise   = a_chg & a_now;
  wire quad_dir = a_now ^ b_prev;

  always_comb begin
    hit = 1'b0;
    dir = 1'b0;
    case (scale)
      M_CLKDIR: begin hit = a_rise;           dir = ~b_now;   end
      M_X1:     begin hit = a_rise & ~b_chg;  dir = ~b_now;   end
      M_X2:     begin hit = a_chg & ~b_chg;   dir = quad_dir; end
      default:  begin hit = a_chg ^ b_chg;    dir = quad_dir; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sync    <= '0;
      b_sync    <= '0;
      a_prev    <= 1'b0;
      b_prev    <= 1'b0;
      cnt_pulse <= 1'b0;
      cnt_up    <= 1'b0;
    end else begin
      a_sync    <= {a_sync[MSB-1:0], enc_a};
      b_sync    <= {b_sync[MSB-1:0], enc_b};
      a_prev    <= a_now;
      b_prev    <= b_now;
      cnt_pulse <= ab_en & hit;
      if (ab_en & hit) cnt_up <= dir;
    end
  end

  AST_NO_COUNT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |=> !cnt_pulse); // R3
  AST_NO_COUNT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (scale != M_CLKDIR && a_now != a_prev && b_now != b_prev) |=> !cnt_pulse); // R8
  AST_X1_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == M_X1 && !(a_now && !a_prev)) |=> !cnt_pulse); // R5
  AST_X2_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == M_X2 && a_now == a_prev) |=> !cnt_pulse); // R6
  AST_CLKDIR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == M_CLKDIR && ab_en && a_now && !a_prev) |=> (cnt_pulse && cnt_up == !$past(b_now))); // R4
  AST_X4_EDGE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == M_X4 && ab_en && (a_now != a_prev) != (b_now != b_prev)) |=> cnt_pulse); // R7

endmodule

// File: tb/quad_decoder_tb.sv
module quad_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_en = 1'b0;
  logic [1:0] scale = 2'b00;
  logic enc_a = 1'b0;
  logic enc_b = 1'b0;
  logic cnt_pulse, cnt_up;

  int n_checks = 0;
  int n_fails = 0;
  int n_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ab_en(ab_en), .scale(scale),
    .enc_a(enc_a), .enc_b(enc_b), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Apply {a,b} after a falling edge; the pulse is due after the third rising edge.
  task automatic step(input string req, input logic a, input logic b,
                      input logic exp_pulse, input logic exp_up);
    enc_a = a;
    enc_b = b;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9", cnt_pulse, 1'b0, "pulse before latency");
    @(posedge clk); @(negedge clk);
    check(req, cnt_pulse, exp_pulse, "pulse");
    if (cnt_pulse) n_pulses++;
    if (exp_pulse) check(req, cnt_up, exp_up, "direction");
    @(posedge clk); @(negedge clk);
    check("R9", cnt_pulse, 1'b0, "pulse one cycle wide");
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", cnt_pulse, 1'b0, "pulse in reset");
    check("R1", cnt_up, 1'b0, "dir in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", cnt_pulse, 1'b0, "pulse after reset");
    check("R1", cnt_up, 1'b0, "dir after reset");
  endtask

  task automatic t_clkdir;
    scale = 2'b00; ab_en = 1'b1;
    step("R4", 1, 0, 1, 1);
    step("R4", 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0);
    step("R4", 1, 1, 1, 0);
    step("R4", 0, 0, 0, 0);
    step("R4", 1, 1, 1, 0);
    step("R4", 0, 1, 0, 0);
    step("R4", 0, 0, 0, 0);
  endtask

  task automatic t_x1;
    scale = 2'b01;
    n_pulses = 0;
    step("R5", 1, 0, 1, 1);
    step("R5", 1, 1, 0, 0);
    step("R5", 0, 1, 0, 0);
    step("R5", 0, 0, 0, 0);
    check("R9", n_pulses == 1, 1'b1, "X1 pulses per cycle");
    step("R5", 0, 1, 0, 0);
    step("R5", 1, 1, 1, 0);
    step("R5", 1, 0, 0, 0);
    step("R5", 0, 0, 0, 0);
  endtask

  task automatic t_x2;
    scale = 2'b10;
    n_pulses = 0;
    step("R6", 1, 0, 1, 1);
    step("R6", 1, 1, 0, 0);
    step("R6", 0, 1, 1, 1);
    step("R6", 0, 0, 0, 0);
    check("R9", n_pulses == 2, 1'b1, "X2 pulses per cycle");
    step("R6", 0, 1, 0, 0);
    step("R6", 1, 1, 1, 0);
    step("R6", 1, 0, 0, 0);
    step("R6", 0, 0, 1, 0);
  endtask

  task automatic t_x4;
    scale = 2'b11;
    n_pulses = 0;
    step("R7", 1, 0, 1, 1);
    step("R7", 1, 1, 1, 1);
    step("R7", 0, 1, 1, 1);
    step("R7", 0, 0, 1, 1);
    check("R9", n_pulses == 4, 1'b1, "X4 pulses per cycle");
    step("R7", 0, 1, 1, 0);
    step("R7", 1, 1, 1, 0);
    step("R7", 1, 0, 1, 0);
    step("R7", 0, 0, 1, 0);
  endtask

  task automatic t_illegal;
    scale = 2'b11;
    step("R8", 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0);
    scale = 2'b10;
    step("R8", 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0);
    scale = 2'b01;
    step("R8", 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0);
  endtask

  task automatic t_disable;
    scale = 2'b11; ab_en = 1'b0;
    step("R3", 1, 0, 0, 0);
    step("R3", 1, 1, 0, 0);
    step("R3", 0, 1, 0, 0);
    step("R3", 0, 0, 0, 0);
    scale = 2'b00;
    step("R3", 1, 0, 0, 0);
    step("R3", 0, 0, 0, 0);
    ab_en = 1'b1;
    step("R3", 1, 0, 1, 1);
    step("R3", 0, 0, 0, 0);
  endtask

  task automatic t_mode_select;
    scale = 2'b11;
    step("R2", 0, 1, 1, 0);
    scale = 2'b10;
    step("R2", 1, 1, 1, 0);
    scale = 2'b01;
    step("R2", 1, 0, 0, 0);
    scale = 2'b00;
    step("R2", 0, 0, 0, 0);
    step("R2", 1, 0, 1, 1);
    step("R2", 0, 0, 0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset;
    t_clkdir;
    t_x1;
    t_x2;
    t_x4;
    t_illegal;
    t_disable;
    t_mode_select;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule